// File: doc/BRIEF.md
# Decrement-and-Test Event Counter

A two's-complement down-counter that serves either as an elapsed-time counter or as a program loop counter. A mode input selects the role. In timing mode the counter steps down once per cycle of the AC power line, about 16.67 ms on a 60 Hz supply. The line-cycle input is asynchronous, so it is synchronized and edge-detected first. When the count wraps from zero to all ones, a single-cycle interrupt request is raised.

In loop mode, software issues a decrement strobe once per loop pass. The wrap from zero to all ones clears a test flag that the program polls, and the interrupt output stays quiet. A load port writes a fresh count at any time. A separate input sets the test flag before a loop begins.

Top module: `dec_test_counter`

## Requirements
- R1: After reset, `count` is 0 and `test_flag` and `irq` are low.
- R2: A cycle with `load_en` high writes `load_val` into `count`, visible after that clock edge. It takes priority over any decrement in the same cycle.
- R3: In loop mode (`mode` = 0), each clock cycle with `dec_strobe` high lowers `count` by one. `line_tick` has no effect on the count.
- R4: In timing mode (`mode` = 1), each rising edge of `line_tick` lowers `count` by exactly one, however long the input stays high. `dec_strobe` has no effect on the count.
- R5: `count` is a 24-bit two's-complement value. A decrement from 0 yields 0xFFFFFF, and further decrements continue down from there (0xFFFFFE next).
- R6: In timing mode, a decrement from 0 drives `irq` high for exactly one clock cycle, in the cycle after the edge that wraps the count.
- R7: In loop mode, `irq` is never asserted, even when the count wraps.
- R8: In loop mode, a decrement from 0 clears `test_flag`.
- R9: `flag_set` sets `test_flag`. A decrement from any nonzero value leaves the flag unchanged. A wrap in timing mode also leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = loop counter, 1 = line-cycle timer |
| load_en | input | 1 | Write `load_val` into the counter |
| load_val | input | 24 | Value to load |
| dec_strobe | input | 1 | Program-issued decrement (loop mode) |
| line_tick | input | 1 | Asynchronous power-line cycle signal (timing mode) |
| flag_set | input | 1 | Set the test flag |
| count | output | 24 | Current count |
| test_flag | output | 1 | Loop test flag |
| irq | output | 1 | Underflow interrupt request (timing mode) |

## Verification
Assertions check four properties on every cycle. A load always wins over a decrement. A decrement steps the count down by exactly one. The interrupt is never more than a single-cycle pulse and never appears in loop mode. A loop-mode wrap always leaves the flag low.

Some behaviour only the bench scenarios can show. A long-held line-cycle input gives one decrement and not many. The unused decrement source in each mode is ignored. The flag survives nonzero decrements and timing-mode wraps. The exact wrap value and the continued descent after it are also covered there.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   typedef enum logic {
      MODE_LOOP   = 1'b0,
      MODE_TIMING = 1'b1
   } dtc_mode_e;
endpackage

// File: rtl/dtc_tick_edge.sv
// Synchronizes an asynchronous tick and emits one pulse per rising edge.
module dtc_tick_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic rise
);
   initial begin
      if (STAGES < 2) $error("dtc_tick_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= tick_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;

   AST_ONE_RISE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R4
endmodule

// File: rtl/dtc_down_core.sv
// Loadable two's-complement down-counter with underflow detect.
module dtc_down_core #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         dec_en,
   output logic [W-1:0] count,
   output logic         wrap
);
   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = W'(1);

   initial begin
      if (W < 2) $error("dtc_down_core: W must be at least 2");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= ZERO;
      else if (load_en) cnt_q <= load_val;
      else if (dec_en)  cnt_q <= cnt_q - ONE;
   end

   assign count = cnt_q;
   assign wrap  = dec_en && !load_en && (cnt_q == ZERO);

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (count == $past(load_val))); // R2
   AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && !load_en) |=> (count == $past(count) - ONE)); // R5
endmodule

// File: rtl/dtc_wrap_route.sv
// Routes an underflow either to an interrupt pulse or to the loop test flag.
module dtc_wrap_route
   import dtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  dtc_mode_e mode,
   input  logic      wrap,
   input  logic      flag_set,
   output logic      irq,
   output logic      test_flag
);
   logic irq_q, flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= wrap && (mode == MODE_TIMING);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                              flag_q <= 1'b0;
      else if (flag_set)                       flag_q <= 1'b1;
      else if (wrap && (mode == MODE_LOOP))    flag_q <= 1'b0;
   end

   assign irq       = irq_q;
   assign test_flag = flag_q;

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R6
   AST_LOOP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && mode == MODE_LOOP) |=> !irq); // R7
   AST_LOOP_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && mode == MODE_LOOP && !flag_set) |=> !test_flag); // R8
endmodule

// File: rtl/dec_test_counter.sv
module dec_test_counter
   import dtc_pkg::*;
#(
   parameter int W           = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mode,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         dec_strobe,
   input  logic         line_tick,
   input  logic         flag_set,
   output logic [W-1:0] count,
   output logic         test_flag,
   output logic         irq
);
   dtc_mode_e mode_e;
   logic      tick_rise, dec_en, wrap;

   assign mode_e = dtc_mode_e'(mode);

   dtc_tick_edge #(.STAGES(SYNC_STAGES)) i_tick (
      .clk(clk), .rst_n(rst_n), .tick_in(line_tick), .rise(tick_rise));

   assign dec_en = (mode_e == MODE_TIMING) ? tick_rise : dec_strobe;

   dtc_down_core #(.W(W)) i_core (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
      .dec_en(dec_en), .count(count), .wrap(wrap));

   dtc_wrap_route i_route (
      .clk(clk), .rst_n(rst_n), .mode(mode_e), .wrap(wrap),
      .flag_set(flag_set), .irq(irq), .test_flag(test_flag));

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (count == '0 && !test_flag && !irq)); // R1
endmodule

// File: tb/test_dec_test_counter.sv
module test_dec_test_counter;
   localparam time CLK_PERIOD = 10ns;
   localparam int  W = 24;

   logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, load_en = 1'b0;
   logic [W-1:0] load_val = '0;
   logic dec_strobe = 1'b0, line_tick = 1'b0, flag_set = 1'b0;
   logic [W-1:0] count;
   logic test_flag, irq;

   int checks = 0, errors = 0, irq_cycles = 0, irq_pulses = 0;
   logic irq_prev = 1'b0;

   typedef struct { logic [W-1:0] c; logic f; string tag; } exp_t;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dec_test_counter i_dec_test_counter (
      .clk(clk), .rst_n(rst_n), .mode(mode), .load_en(load_en),
      .load_val(load_val), .dec_strobe(dec_strobe), .line_tick(line_tick),
      .flag_set(flag_set), .count(count), .test_flag(test_flag), .irq(irq));

   // monitor: compares outputs against queued expectations, tracks irq
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq) irq_cycles++;
         if (irq && !irq_prev) irq_pulses++;
         irq_prev = irq;
      end
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (count !== e.c || test_flag !== e.f) begin
            errors++;
            $display("FAIL %s: count=%h flag=%b expected count=%h flag=%b",
                     e.tag, count, test_flag, e.c, e.f);
         end
      end
   end

   task automatic expect_state(input logic [W-1:0] c, input logic f, input string tag);
      exp_t e;
      @(posedge clk); #1;
      e.c = c; e.f = f; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk); @(negedge clk);
   endtask

   task automatic check_int(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_load(input logic [W-1:0] v, input logic with_dec);
      @(negedge clk); load_en = 1'b1; load_val = v; dec_strobe = with_dec;
      @(negedge clk); load_en = 1'b0; dec_strobe = 1'b0;
   endtask

   task automatic do_strobe(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); dec_strobe = 1'b1;
         @(negedge clk); dec_strobe = 1'b0;
      end
   endtask

   task automatic do_tick(input int hold);
      @(negedge clk); line_tick = 1'b1;
      repeat (hold) @(negedge clk);
      line_tick = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic do_flag_set();
      @(negedge clk); flag_set = 1'b1;
      @(negedge clk); flag_set = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      expect_state(24'h0, 1'b0, "R1 reset state");
      check_int(irq_cycles, 0, "R1 irq low after reset");

      // loop mode
      do_load(24'h000005, 1'b0);
      expect_state(24'h000005, 1'b0, "R2 load");
      do_flag_set();
      expect_state(24'h000005, 1'b1, "R9 flag_set");
      do_strobe(3);
      expect_state(24'h000002, 1'b1, "R3/R9 strobe decrements, flag kept");
      do_tick(6);
      expect_state(24'h000002, 1'b1, "R3 line_tick ignored in loop mode");
      do_strobe(2);
      expect_state(24'h000000, 1'b1, "R3 reach zero");
      do_strobe(1);
      expect_state(24'hFFFFFF, 1'b0, "R5/R8 wrap clears flag");
      check_int(irq_cycles, 0, "R7 no irq in loop mode");
      do_strobe(1);
      expect_state(24'hFFFFFE, 1'b0, "R5 continues after wrap");
      do_load(24'h000010, 1'b1);
      expect_state(24'h000010, 1'b0, "R2 load beats decrement");

      // timing mode
      @(negedge clk); mode = 1'b1;
      do_load(24'h000002, 1'b0);
      do_flag_set();
      do_tick(2);
      expect_state(24'h000001, 1'b1, "R4 one tick one decrement");
      do_strobe(2);
      expect_state(24'h000001, 1'b1, "R4 strobe ignored in timing mode");
      do_tick(12);
      expect_state(24'h000000, 1'b1, "R4 long tick single decrement");
      check_int(irq_cycles, 0, "R6 no irq before wrap");
      do_tick(3);
      expect_state(24'hFFFFFF, 1'b1, "R5/R9 timing wrap keeps flag");
      check_int(irq_pulses, 1, "R6 one irq pulse");
      check_int(irq_cycles, 1, "R6 irq lasts one cycle");
      do_tick(3);
      expect_state(24'hFFFFFE, 1'b1, "R5 timing continues after wrap");
      check_int(irq_pulses, 1, "R6 no irq on nonzero decrement");

      finish_run();
   end
endmodule